// File: doc/BRIEF.md
# Integer Register File with Deferred Speculative Faults

This block is the integer register file of an in-order core that supports control speculation. Each entry holds a 64-bit value and a poison flag. A speculative load that would have faulted does not trap. It leaves its destination marked as poisoned. The poison then travels through arithmetic, one operation at a time. The fault becomes visible only when a non-speculative consumer, such as a store, touches the value, or when a speculation-check operation tests it and sends control to a recovery routine.

Each cycle the block accepts one operation. The operation reads two source registers through two read ports and may write one destination through the single write port. The same cycle can also carry a load completion on a separate response interface, which holds the destination, the data, a fault flag and a speculative flag. The upstream scheduler never presents a register-writing operation and a load completion in the same cycle, so the two never compete for the write port. Every result, store request, exception and redirect is registered and appears one clock edge after its inputs.

Top module: `nat_deferred_rf`

## Requirements
- R1: While reset is high and after it is released, every register holds zero with its poison flag clear, and every output is low or zero.
- R2: Register 0 always reads as zero with the poison flag clear, and writes aimed at it have no effect.
- R3: The arithmetic opcodes are ADD=1, SUB=2, AND=3, OR=4, XOR=5 (source A with source B) and ADDI=6 (source A plus the immediate). Each one writes its result to the destination and shows it on the result port one cycle later. The result is poisoned exactly when a source it uses is poisoned.
- R4: A speculative load completion (spec=1) that carries a fault raises no exception. It writes its destination with data zero and the poison flag set.
- R5: A non-speculative load completion (spec=0) that carries a fault raises the load-fault exception one cycle later and leaves its destination unchanged.
- R6: A load completion without a fault writes its data to the destination with the poison flag clear.
- R7: STORE (opcode 7) with either source poisoned raises the poisoned-use exception one cycle later and issues no store. With both sources clean it issues a store one cycle later, with source A as the address and source B as the data.
- R8: CHECK (opcode 8) on a poisoned source A raises the redirect one cycle later, targeting the immediate, and raises no exception. On a clean source A it does nothing.
- R9: SAVE (opcode 9) shows the data and poison flag of source A on the result port one cycle later and never traps. RESTORE (opcode 10) writes the immediate and the supplied poison flag into the destination. Opcode 0 and codes above 10 do nothing.
- R10: An operation that reads a register in the same cycle that a load completion writes it sees the newly written data and poison flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Opcode, encodings in R3, R7, R8 and R9 |
| op_dst | input | 7 | Destination register |
| op_src_a | input | 7 | Source register A |
| op_src_b | input | 7 | Source register B |
| op_imm | input | 64 | Immediate, restore data or recovery target |
| op_nat_in | input | 1 | Poison flag written by RESTORE |
| ld_valid | input | 1 | A load completion is presented this cycle |
| ld_spec | input | 1 | The completing load was speculative |
| ld_fault | input | 1 | The completing load faulted |
| ld_dst | input | 7 | Destination register of the load |
| ld_data | input | 64 | Loaded data |
| res_valid | output | 1 | Result port holds an arithmetic or SAVE result |
| res_data | output | 64 | Result data |
| res_nat | output | 1 | Result poison flag |
| st_valid | output | 1 | A store request is issued |
| st_addr | output | 64 | Store address |
| st_data | output | 64 | Store data |
| exc_nat_use | output | 1 | Poisoned operand reached a store |
| exc_ld_fault | output | 1 | Non-speculative load faulted |
| redirect_valid | output | 1 | Speculation check failed, enter recovery |
| redirect_target | output | 64 | Recovery target |

## Verification
Every output of the block is due exactly one rising edge after the operation or load completion that causes it. The bench therefore drives each cycle's inputs on a falling edge, steps across one rising edge, and compares all outputs at the next falling edge against a reference register model it updated when it drove them. A register write becomes visible to the operation presented in the following cycle. The exception is a load completion, whose value the model applies before it resolves the sources of an operation in the same cycle, matching R10. A closing sweep saves every register and compares it with the model, which shows how the whole stream of writes has accumulated.

// File: rtl/nat_rf_pkg.sv
package nat_rf_pkg;

    parameter int XLEN = 64;

    typedef enum logic [3:0] {
        OP_NOP     = 4'd0,
        OP_ADD     = 4'd1,
        OP_SUB     = 4'd2,
        OP_AND     = 4'd3,
        OP_OR      = 4'd4,
        OP_XOR     = 4'd5,
        OP_ADDI    = 4'd6,
        OP_STORE   = 4'd7,
        OP_CHECK   = 4'd8,
        OP_SAVE    = 4'd9,
        OP_RESTORE = 4'd10
    } op_e;

    typedef struct packed {
        logic            nat;
        logic [XLEN-1:0] data;
    } word_t;

    function automatic logic op_is_alu(op_e op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND) ||
               (op == OP_OR)  || (op == OP_XOR) || (op == OP_ADDI);
    endfunction

    function automatic logic op_uses_b(op_e op);
        return (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND) ||
               (op == OP_OR)  || (op == OP_XOR) || (op == OP_STORE);
    endfunction

    function automatic logic op_writes(op_e op);
        return op_is_alu(op) || (op == OP_RESTORE);
    endfunction

endpackage

// File: rtl/nat_rf_store.sv
module nat_rf_store
    import nat_rf_pkg::*;
#(
    parameter int NREGS  = 128,
    parameter int NPORTS = 2,
    localparam int AW    = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] rd_addr [NPORTS],
    output word_t         rd_word [NPORTS],
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  word_t         wd,
    input  logic          fwd_valid,
    input  logic [AW-1:0] fwd_addr,
    input  word_t         fwd_word
);

    word_t regs [NREGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) begin
                regs[i] <= '0;
            end
        end else if (we && (wa != '0)) begin
            regs[wa] <= wd;
        end
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_rd
        assign rd_word[p] = (rd_addr[p] == '0)                      ? '0 :
                            (fwd_valid && (fwd_addr == rd_addr[p])) ? fwd_word :
                                                                      regs[rd_addr[p]];

        // R2: register zero never carries poison on any read port
        a_r2_zero_clean: assert property (@(posedge clk) disable iff (rst)
            (rd_addr[p] == '0) |-> (rd_word[p] == '0));
    end

    // R6: a write to a nonzero register is held in the array on the next edge
    a_r6_write_lands: assert property (@(posedge clk) disable iff (rst)
        (we && (wa != '0)) |=> (regs[$past(wa)] == $past(wd)));

endmodule

// File: rtl/nat_exec.sv
module nat_exec
    import nat_rf_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  op_e             op,
    input  word_t           src_a,
    input  word_t           src_b,
    input  logic [XLEN-1:0] imm,
    output word_t           alu_out
);

    logic b_used;
    assign b_used = op_uses_b(op);

    always_comb begin
        alu_out.nat = src_a.nat | (b_used & src_b.nat);
        unique case (op)
            OP_ADD:  alu_out.data = src_a.data + src_b.data;
            OP_SUB:  alu_out.data = src_a.data - src_b.data;
            OP_AND:  alu_out.data = src_a.data & src_b.data;
            OP_OR:   alu_out.data = src_a.data | src_b.data;
            OP_XOR:  alu_out.data = src_a.data ^ src_b.data;
            OP_ADDI: alu_out.data = src_a.data + imm;
            default: alu_out.data = '0;
        endcase
    end

    // R3: a poisoned source used by an arithmetic operation yields a poisoned result
    a_r3_poison_spreads: assert property (@(posedge clk) disable iff (rst)
        (op_is_alu(op) && (src_a.nat || (op != OP_ADDI && src_b.nat))) |-> alu_out.nat);

endmodule

// File: rtl/nat_spec_ctrl.sv
module nat_spec_ctrl
    import nat_rf_pkg::*;
#(
    parameter int NREGS = 128,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            op_valid,
    input  op_e             op,
    input  logic [AW-1:0]   op_dst,
    input  logic [XLEN-1:0] op_imm,
    input  logic            op_nat_in,
    input  word_t           src_a,
    input  word_t           src_b,
    input  word_t           alu_out,
    input  logic            ld_valid,
    input  logic            ld_spec,
    input  logic            ld_fault,
    input  logic            ld_commit,
    input  logic [AW-1:0]   ld_dst,
    input  word_t           ld_word,
    output logic            we,
    output logic [AW-1:0]   wa,
    output word_t           wd,
    output logic            res_valid,
    output logic [XLEN-1:0] res_data,
    output logic            res_nat,
    output logic            st_valid,
    output logic [XLEN-1:0] st_addr,
    output logic [XLEN-1:0] st_data,
    output logic            exc_nat_use,
    output logic            exc_ld_fault,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_target
);

    logic is_save, is_store, is_check, is_alu, op_wr, store_poisoned;

    assign is_save        = op_valid && (op == OP_SAVE);
    assign is_store       = op_valid && (op == OP_STORE);
    assign is_check       = op_valid && (op == OP_CHECK);
    assign is_alu         = op_valid && op_is_alu(op);
    assign op_wr          = op_valid && op_writes(op);
    assign store_poisoned = src_a.nat || src_b.nat;

    // single write port: load completions and writing operations never coincide
    always_comb begin
        we = 1'b0;
        wa = '0;
        wd = '0;
        if (ld_commit) begin
            we = 1'b1;
            wa = ld_dst;
            wd = ld_word;
        end else if (op_wr) begin
            we = 1'b1;
            wa = op_dst;
            wd = (op == OP_RESTORE) ? word_t'{nat: op_nat_in, data: op_imm} : alu_out;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid       <= 1'b0;
            res_data        <= '0;
            res_nat         <= 1'b0;
            st_valid        <= 1'b0;
            st_addr         <= '0;
            st_data         <= '0;
            exc_nat_use     <= 1'b0;
            exc_ld_fault    <= 1'b0;
            redirect_valid  <= 1'b0;
            redirect_target <= '0;
        end else begin
            res_valid       <= is_alu || is_save;
            res_data        <= is_save ? src_a.data : alu_out.data;
            res_nat         <= is_save ? src_a.nat  : alu_out.nat;
            st_valid        <= is_store && !store_poisoned;
            st_addr         <= src_a.data;
            st_data         <= src_b.data;
            exc_nat_use     <= is_store && store_poisoned;
            exc_ld_fault    <= ld_valid && ld_fault && !ld_spec;
            redirect_valid  <= is_check && src_a.nat;
            redirect_target <= op_imm;
        end
    end

    // R4: a speculative completion never traps, whatever its fault flag
    a_r4_spec_no_trap: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && ld_spec) |=> !exc_ld_fault);

    // R5: a faulting non-speculative completion claims no write to its destination
    a_r5_fault_no_write: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && ld_fault && !ld_spec) |-> !(we && (wa == ld_dst)));

    // R7: a store either issues or traps, never both
    a_r7_store_or_trap: assert property (@(posedge clk) disable iff (rst)
        !(st_valid && exc_nat_use));

    // R8: a redirect comes with neither a trap nor a store
    a_r8_redirect_alone: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |-> (!exc_nat_use && !st_valid));

endmodule

// File: rtl/nat_deferred_rf.sv
module nat_deferred_rf
    import nat_rf_pkg::*;
#(
    parameter int NREGS = 128,
    localparam int AW   = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            op_valid,
    input  logic [3:0]      op_code,
    input  logic [AW-1:0]   op_dst,
    input  logic [AW-1:0]   op_src_a,
    input  logic [AW-1:0]   op_src_b,
    input  logic [XLEN-1:0] op_imm,
    input  logic            op_nat_in,
    input  logic            ld_valid,
    input  logic            ld_spec,
    input  logic            ld_fault,
    input  logic [AW-1:0]   ld_dst,
    input  logic [XLEN-1:0] ld_data,
    output logic            res_valid,
    output logic [XLEN-1:0] res_data,
    output logic            res_nat,
    output logic            st_valid,
    output logic [XLEN-1:0] st_addr,
    output logic [XLEN-1:0] st_data,
    output logic            exc_nat_use,
    output logic            exc_ld_fault,
    output logic            redirect_valid,
    output logic [XLEN-1:0] redirect_target
);

    localparam int NPORTS = 2;

    op_e           op;
    logic [AW-1:0] rd_addr [NPORTS];
    word_t         rd_word [NPORTS];
    word_t         alu_out, ld_word, wd;
    logic          ld_commit, we;
    logic [AW-1:0] wa;

    assign op         = op_e'(op_code);
    assign rd_addr[0] = op_src_a;
    assign rd_addr[1] = op_src_b;

    // a faulting speculative load leaves zero data under the poison flag
    assign ld_commit    = ld_valid && (ld_spec || !ld_fault);
    assign ld_word.nat  = ld_fault;
    assign ld_word.data = ld_fault ? '0 : ld_data;

    nat_rf_store #(.NREGS(NREGS), .NPORTS(NPORTS)) u_store (
        .clk       (clk),
        .rst       (rst),
        .rd_addr   (rd_addr),
        .rd_word   (rd_word),
        .we        (we),
        .wa        (wa),
        .wd        (wd),
        .fwd_valid (ld_commit),
        .fwd_addr  (ld_dst),
        .fwd_word  (ld_word)
    );

    nat_exec u_exec (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .src_a   (rd_word[0]),
        .src_b   (rd_word[1]),
        .imm     (op_imm),
        .alu_out (alu_out)
    );

    nat_spec_ctrl #(.NREGS(NREGS)) u_ctrl (
        .clk             (clk),
        .rst             (rst),
        .op_valid        (op_valid),
        .op              (op),
        .op_dst          (op_dst),
        .op_imm          (op_imm),
        .op_nat_in       (op_nat_in),
        .src_a           (rd_word[0]),
        .src_b           (rd_word[1]),
        .alu_out         (alu_out),
        .ld_valid        (ld_valid),
        .ld_spec         (ld_spec),
        .ld_fault        (ld_fault),
        .ld_commit       (ld_commit),
        .ld_dst          (ld_dst),
        .ld_word         (ld_word),
        .we              (we),
        .wa              (wa),
        .wd              (wd),
        .res_valid       (res_valid),
        .res_data        (res_data),
        .res_nat         (res_nat),
        .st_valid        (st_valid),
        .st_addr         (st_addr),
        .st_data         (st_data),
        .exc_nat_use     (exc_nat_use),
        .exc_ld_fault    (exc_ld_fault),
        .redirect_valid  (redirect_valid),
        .redirect_target (redirect_target)
    );

    // R10: forwarding covers load completions only, so they must not meet a writing op
    a_r10_one_writer: assert property (@(posedge clk) disable iff (rst)
        !(ld_valid && op_valid && op_writes(op)));

endmodule

// File: tb/nat_deferred_rf_bench.sv
module nat_deferred_rf_bench;

    localparam logic [3:0] C_NOP = 4'd0, C_ADD = 4'd1, C_SUB = 4'd2, C_AND = 4'd3,
                           C_OR = 4'd4, C_XOR = 4'd5, C_ADDI = 4'd6, C_STORE = 4'd7,
                           C_CHECK = 4'd8, C_SAVE = 4'd9, C_RESTORE = 4'd10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [6:0]  op_dst = '0, op_src_a = '0, op_src_b = '0;
    logic [63:0] op_imm = '0;
    logic        op_nat_in = 1'b0;
    logic        ld_valid = 1'b0, ld_spec = 1'b0, ld_fault = 1'b0;
    logic [6:0]  ld_dst = '0;
    logic [63:0] ld_data = '0;
    logic        res_valid, res_nat, st_valid, exc_nat_use, exc_ld_fault, redirect_valid;
    logic [63:0] res_data, st_addr, st_data, redirect_target;

    int n_tests = 0;
    int n_fail  = 0;

    logic [63:0] m_data [128];
    logic        m_nat  [128];

    always #2 clk = ~clk;

    nat_deferred_rf u_nat_deferred_rf (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .op_dst(op_dst),
        .op_src_a(op_src_a), .op_src_b(op_src_b), .op_imm(op_imm), .op_nat_in(op_nat_in),
        .ld_valid(ld_valid), .ld_spec(ld_spec), .ld_fault(ld_fault), .ld_dst(ld_dst),
        .ld_data(ld_data), .res_valid(res_valid), .res_data(res_data), .res_nat(res_nat),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .exc_nat_use(exc_nat_use),
        .exc_ld_fault(exc_ld_fault), .redirect_valid(redirect_valid),
        .redirect_target(redirect_target)
    );

    task automatic chk(input string req, input logic [159:0] act, input logic [159:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic writes_reg(input logic [3:0] op);
        return (op >= C_ADD && op <= C_ADDI) || op == C_RESTORE;
    endfunction

    task automatic step(input string rt, input logic [3:0] op, input logic [6:0] dst,
                        input logic [6:0] sa, input logic [6:0] sb, input logic [63:0] imm,
                        input logic nin, input logic lv, input logic ls, input logic lf,
                        input logic [6:0] ld, input logic [63:0] ldat);
        logic [63:0] ad, bd, rd;
        logic        an, bn, rn, e_res, e_st, e_use, e_ldf, e_rd;
        string       rtag, ltag;
        op_valid = 1'b1; op_code = op; op_dst = dst; op_src_a = sa; op_src_b = sb;
        op_imm = imm; op_nat_in = nin;
        ld_valid = lv; ld_spec = ls; ld_fault = lf; ld_dst = ld; ld_data = ldat;
        e_ldf = lv && lf && !ls;
        if (lv && !e_ldf && ld != 0) begin
            m_data[ld] = lf ? 64'd0 : ldat;
            m_nat[ld]  = lf;
        end
        ad = m_data[sa]; an = m_nat[sa]; bd = m_data[sb]; bn = m_nat[sb];
        e_res = 0; e_st = 0; e_use = 0; e_rd = 0; rd = '0; rn = 0;
        case (op)
            C_ADD:   begin e_res = 1; rd = ad + bd; rn = an | bn; end
            C_SUB:   begin e_res = 1; rd = ad - bd; rn = an | bn; end
            C_AND:   begin e_res = 1; rd = ad & bd; rn = an | bn; end
            C_OR:    begin e_res = 1; rd = ad | bd; rn = an | bn; end
            C_XOR:   begin e_res = 1; rd = ad ^ bd; rn = an | bn; end
            C_ADDI:  begin e_res = 1; rd = ad + imm; rn = an; end
            C_STORE: begin e_use = an | bn; e_st = !(an | bn); end
            C_CHECK: e_rd = an;
            C_SAVE:  begin e_res = 1; rd = ad; rn = an; end
            default: ;
        endcase
        if (dst != 0 && op >= C_ADD && op <= C_ADDI) begin
            m_data[dst] = rd; m_nat[dst] = rn;
        end
        if (dst != 0 && op == C_RESTORE) begin
            m_data[dst] = imm; m_nat[dst] = nin;
        end
        @(posedge clk);
        @(negedge clk);
        rtag = (rt != "") ? rt : ((op == C_SAVE) ? "R9" : "R3");
        ltag = ls ? "R4" : (lf ? "R5" : "R6");
        chk(rtag, {res_valid, res_valid & res_nat, res_valid ? res_data : 64'd0},
                  {e_res, rn, rd});
        chk("R7", {st_valid, exc_nat_use, st_valid ? {st_addr, st_data} : 128'd0},
                  {e_st, e_use, e_st ? {ad, bd} : 128'd0});
        chk("R8", {redirect_valid, redirect_valid ? redirect_target : 64'd0},
                  {e_rd, e_rd ? imm : 64'd0});
        chk(ltag, {159'd0, exc_ld_fault}, {159'd0, e_ldf});
        op_valid = 1'b0; ld_valid = 1'b0;
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        for (int i = 0; i < 128; i++) begin
            m_data[i] = '0; m_nat[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: outputs quiet right after reset
        chk("R1", {res_valid, st_valid, exc_nat_use, exc_ld_fault, redirect_valid,
                   res_data, redirect_target}, '0);
        step("R1", C_SAVE, 0, 7'd5, 0, 0, 0, 0, 0, 0, 0, 0);
        // R2: writes to register zero vanish
        step("R2", C_RESTORE, 0, 0, 0, 64'hdead, 1, 0, 0, 0, 0, 0);
        step("R2", C_SAVE, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R2", C_NOP, 0, 0, 0, 0, 0, 1, 0, 0, 7'd0, 64'h1234);
        step("R2", C_SAVE, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R6: clean loads, then R4: speculative fault poisons r3
        step("R6", C_NOP, 0, 0, 0, 0, 0, 1, 0, 0, 7'd1, 64'h10);
        step("R6", C_NOP, 0, 0, 0, 0, 0, 1, 1, 0, 7'd2, 64'h20);
        step("R4", C_NOP, 0, 0, 0, 0, 0, 1, 1, 1, 7'd3, 64'h55);
        step("R4", C_SAVE, 0, 7'd3, 0, 0, 0, 0, 0, 0, 0, 0);
        // R3: poison spreads through arithmetic
        step("R3", C_ADD, 7'd4, 7'd3, 7'd1, 0, 0, 0, 0, 0, 0, 0);
        step("R3", C_ADDI, 7'd8, 7'd1, 7'd3, 64'h5, 0, 0, 0, 0, 0, 0);
        // R7: poisoned and clean stores
        step("R7", C_STORE, 0, 7'd1, 7'd4, 0, 0, 0, 0, 0, 0, 0);
        step("R7", C_STORE, 0, 7'd1, 7'd2, 0, 0, 0, 0, 0, 0, 0);
        // R8: checks on poisoned and clean registers
        step("R8", C_CHECK, 0, 7'd3, 0, 64'h400, 0, 0, 0, 0, 0, 0);
        step("R8", C_CHECK, 0, 7'd1, 0, 64'h400, 0, 0, 0, 0, 0, 0);
        // R5: non-speculative fault traps and leaves r6 alone
        step("R5", C_NOP, 0, 0, 0, 0, 0, 1, 0, 1, 7'd6, 64'h66);
        step("R5", C_SAVE, 0, 7'd6, 0, 0, 0, 0, 0, 0, 0, 0);
        // R10: same-cycle load completion is seen by the reader
        step("R10", C_SAVE, 0, 7'd7, 0, 0, 0, 1, 0, 0, 7'd7, 64'h77);
        step("R10", C_SAVE, 0, 7'd9, 0, 0, 0, 1, 1, 1, 7'd9, 64'h99);
        // R9: restore with poison, then save
        step("R9", C_RESTORE, 7'd9, 0, 0, 64'hcafe, 1, 0, 0, 0, 0, 0);
        step("R9", C_SAVE, 0, 7'd9, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R9", C_RESTORE, 7'd9, 0, 0, 64'hbeef, 0, 0, 0, 0, 0, 0);
        step("R9", C_SAVE, 0, 7'd9, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R9", 4'd13, 7'd9, 7'd1, 7'd2, 64'h1, 1, 0, 0, 0, 0, 0);
        step("R9", C_SAVE, 0, 7'd9, 0, 0, 0, 0, 0, 0, 0, 0);
        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic [3:0] op;
            logic       lv;
            op = 4'($urandom_range(0, 11));
            lv = ($urandom_range(0, 9) < 4) && !writes_reg(op);
            step("", op, 7'($urandom_range(0, 15)), 7'($urandom_range(0, 15)),
                 7'($urandom_range(0, 15)), {$urandom, $urandom}, 1'($urandom),
                 lv, 1'($urandom), $urandom_range(0, 4) == 0,
                 7'($urandom_range(0, 15)), {$urandom, $urandom});
        end
        // R6: final sweep of every register against the model
        for (int r = 0; r < 128; r++) begin
            step("R6", C_SAVE, 0, 7'(r), 0, 0, 0, 0, 0, 0, 0, 0);
        end
        summary();
        $finish;
    end

endmodule